// File: doc/BRIEF.md
# SMBus Two-Region Byte Memory Slave

This block is an SMBus target that exposes a 256-byte address space in two halves. The lower 128 bytes are a fixed information table, computed at elaboration from two parameters. The upper 128 bytes are writable scratch storage. The host picks a byte with the command code of a Write Byte or a Read Byte packet. The most significant bit of that code selects the half.

SCL and SDA are brought into the clock domain through synchronizer chains. SDA is driven only as an open-drain pull-down enable. Three strap inputs form the low part of the target address, so up to eight of these blocks can share one bus. A scratch write starts a settling interval. While it runs, the block raises a busy output and refuses its own address.

Top module: `smb_dual_mem_slave`

## Requirements
- R1: The block acknowledges an address byte whose bits 7..1 equal binary 1010 followed by strap_i[2], strap_i[1], strap_i[0]; bit 0 is the direction (0 write, 1 read). An address with any other strap value gets no acknowledge.
- R2: After an address that does not match, the block drives nothing until the next START, and the bytes that follow have no effect on either region.
- R3: A Write Byte whose command has bit 7 = 1 acknowledges all three bytes and stores the data at scratch offset command[6:0].
- R4: A Write Byte whose command has bit 7 = 0 acknowledges all three bytes, leaves the table unchanged and does not raise busy_o.
- R5: A Read Byte (write address, command, repeated START, read address) acknowledges the three host bytes and returns the byte at the command address, MSB first.
- R6: Table byte at offset i (0..127) equals (i*ROM_MULT + ROM_KEY) mod 256, with defaults ROM_MULT = 3 and ROM_KEY = 8'h5A.
- R7: A committed scratch write holds busy_o high for exactly SETTLE_CYCLES clock cycles. While busy_o is high, the block does not acknowledge its own address.
- R8: The block changes its SDA drive only while SCL is low. It releases SDA after each acknowledge clock and after the last bit of read data.
- R9: A STOP at any point returns the block to idle with SDA released. A START at any point restarts address reception and keeps the last latched command code.
- R10: After reset, SDA is released, busy_o is low and every scratch byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| strap_i | input | 3 | Device select straps, low address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Settling interval after a scratch write |

## Verification
Byte transfers are run at the table's first and last offsets and at scratch offsets across the half, including the top byte 0xFF. These show whether the command MSB alone steers the region and whether the low seven bits index correctly. Write Byte packets aimed at the table are interleaved with read-backs of the same offsets. This separates "acknowledged and discarded" from "stored" and from "refused". Addresses with a wrong strap value, addresses sent during the settling interval, and a strap change are used to tell a match failure apart from a busy refusal. STOP and START are also cut into the middle of a byte, showing whether the byte machine resets cleanly and whether the latched command survives a restart.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int BYTE_W = 8;
   localparam int MEM_AW = 8;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK,
      ST_WAIT
   } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smb_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_store.sv
module smb_store #(
   parameter int   AW       = 8,
   parameter int   DW       = 8,
   parameter int   ROM_MULT = 3,
   parameter logic [7:0] ROM_KEY = 8'h5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int HALF = 1 << (AW - 1);
   localparam int IW   = AW - 1;

   if (AW < 2) begin : g_bad_aw
      $error("smb_store: AW must be at least 2");
   end

   logic [DW-1:0] rom   [HALF];
   logic [DW-1:0] sram  [HALF];

   for (genvar i = 0; i < HALF; i++) begin : g_rom
      assign rom[i] = DW'(i * ROM_MULT + int'(ROM_KEY));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < HALF; k++) sram[k] <= '0;
      end else if (we) begin
         sram[waddr[IW-1:0]] <= wdata;
      end
   end

   logic unused_waddr_msb;
   assign unused_waddr_msb = waddr[AW-1];

   assign rdata = raddr[AW-1] ? sram[raddr[IW-1:0]] : rom[raddr[IW-1:0]];
endmodule

// File: rtl/smb_settle_timer.sv
module smb_settle_timer #(
   parameter int CYCLES = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic busy
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("smb_settle_timer: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (kick)       cnt <= CW'(CYCLES);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/smb_dual_mem_slave.sv
module smb_dual_mem_slave
   import smb_pkg::*;
#(
   parameter int   SYNC_STAGES   = 2,
   parameter int   SETTLE_CYCLES = 2000,
   parameter int   ROM_MULT      = 3,
   parameter logic [7:0] ROM_KEY = 8'h5A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   output logic       sda_oe_o,
   output logic       busy_o
);
   localparam logic [3:0] BITS = 4'd8;
   localparam int         TOPB = BYTE_W - 1;

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   smb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   smb_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   smb_bus_events i_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   smb_state_e        state;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh, cmd_q, wdata_q;
   logic              rw_q, mem_we;
   logic [BYTE_W-1:0] rd_data;
   logic              rx_phase, byte_done, addr_hit;

   smb_store #(.AW(MEM_AW), .DW(BYTE_W), .ROM_MULT(ROM_MULT), .ROM_KEY(ROM_KEY)) i_store (
      .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(cmd_q), .wdata(wdata_q),
      .raddr(cmd_q), .rdata(rd_data));

   smb_settle_timer #(.CYCLES(SETTLE_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .kick(mem_we), .busy(busy_o));

   assign rx_phase  = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
   assign byte_done = scl_fall && (bitcnt == BITS);
   assign addr_hit  = (rx_sh[TOPB:1] == {DEV_TYPE, strap_i}) && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         cmd_q    <= '0;
         wdata_q  <= '0;
         rw_q     <= 1'b0;
         mem_we   <= 1'b0;
         sda_oe_o <= 1'b0;
      end else begin
         mem_we <= 1'b0;
         if (stop_det) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else if (start_det) begin
            state    <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else begin
            if (rx_phase && scl_rise) begin
               rx_sh  <= {rx_sh[TOPB-1:0], sda_s};
               bitcnt <= bitcnt + 1'b1;
            end
            case (state)
               ST_ADDR: if (byte_done) begin
                  bitcnt <= '0;
                  if (addr_hit) begin
                     rw_q     <= rx_sh[0];
                     sda_oe_o <= 1'b1;
                     state    <= ST_ADDR_ACK;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
               ST_ADDR_ACK: if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw_q) begin
                     tx_sh    <= rd_data;
                     sda_oe_o <= ~rd_data[TOPB];
                     state    <= ST_RDATA;
                  end else begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_CMD;
                  end
               end
               ST_CMD: if (byte_done) begin
                  bitcnt   <= '0;
                  cmd_q    <= rx_sh;
                  sda_oe_o <= 1'b1;
                  state    <= ST_CMD_ACK;
               end
               ST_CMD_ACK: if (scl_fall) begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_WDATA;
               end
               ST_WDATA: if (byte_done) begin
                  bitcnt   <= '0;
                  wdata_q  <= rx_sh;
                  mem_we   <= cmd_q[TOPB];
                  sda_oe_o <= 1'b1;
                  state    <= ST_WDATA_ACK;
               end
               ST_WDATA_ACK: if (scl_fall) begin
                  sda_oe_o <= 1'b0;
                  state    <= ST_WAIT;
               end
               ST_RDATA: if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe_o <= 1'b0;
                     state    <= ST_RDATA_ACK;
                  end else begin
                     tx_sh    <= {tx_sh[TOPB-1:0], 1'b0};
                     sda_oe_o <= ~tx_sh[TOPB-1];
                     bitcnt   <= bitcnt + 1'b1;
                  end
               end
               ST_RDATA_ACK: if (scl_fall) state <= ST_WAIT;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/smb_slave_checker.sv
module smb_slave_checker
   import smb_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input smb_state_e state,
   input logic       sda_oe,
   input logic       busy,
   input logic       mem_we,
   input logic [7:0] cmd,
   input logic       stop_det,
   input logic [7:0] rx_byte,
   input logic [2:0] strap
);
   // R1: an address acknowledge only follows a byte carrying the strap address
   p_addr_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK && $past(state) == ST_ADDR)
      |-> ($past(rx_byte[7:1]) == {DEV_TYPE, $past(strap)}));

   // R4: the table half is never written
   p_rom_write_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> cmd[7]);

   // R7: a committed write starts the settling interval
   p_we_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> busy);

   // R7: no address acknowledge while settling
   p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> !$past(busy));

   // R8: SDA drive holds while SCL stays high
   p_sda_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

   // R9: STOP returns to idle with SDA released
   p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));
endmodule

bind smb_dual_mem_slave smb_slave_checker i_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .state(state), .sda_oe(sda_oe_o),
   .busy(busy_o), .mem_we(mem_we), .cmd(cmd_q), .stop_det(stop_det),
   .rx_byte(rx_sh), .strap(strap_i));

// File: tb/test_smb_dual_mem_slave.sv
`timescale 1ns/1ps
module test_smb_dual_mem_slave;
   localparam int SETTLE = 600;
   localparam int Q      = 8;
   localparam logic [2:0] STRAP = 3'b101;
   localparam int NV = 11;
   // {is_read, command, write data}
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 8'h00, 8'h00}, {1'b1, 8'h7F, 8'h00}, {1'b0, 8'h80, 8'hA5},
      {1'b1, 8'h80, 8'h00}, {1'b0, 8'h05, 8'h11}, {1'b1, 8'h05, 8'h00},
      {1'b0, 8'hFF, 8'h3C}, {1'b1, 8'hFF, 8'h00}, {1'b1, 8'h81, 8'h00},
      {1'b0, 8'hC3, 8'h96}, {1'b1, 8'hC3, 8'h00}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_h = 1'b1;
   logic sda_h = 1'b1;
   logic [2:0] strap = STRAP;
   logic sda_oe, busy;
   logic sda_bus;
   assign sda_bus = sda_h & ~sda_oe;

   always #2.5 clk = ~clk;

   smb_dual_mem_slave #(.SETTLE_CYCLES(SETTLE)) i_smb_dual_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
      .strap_i(strap), .sda_oe_o(sda_oe), .busy_o(busy));

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int busy_cnt = 0;
   int r8_viol = 0;
   logic scl_p = 1'b1, oe_p = 1'b0;
   logic [7:0] model [256];

   always @(posedge clk) begin
      if (busy) busy_cnt <= busy_cnt + 1;
      if (rst_n && scl_p && scl_h && (oe_p != sda_oe)) r8_viol <= r8_viol + 1;
      scl_p <= scl_h;
      oe_p  <= sda_oe;
   end

   function automatic logic [7:0] rom_byte(input int i);
      return 8'(i * 3 + 'h5A);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_h = 1; scl_h = 1; qw(); sda_h = 0; qw(); scl_h = 0; qw();
   endtask
   task automatic bus_rstart();
      sda_h = 1; qw(); scl_h = 1; qw(); sda_h = 0; qw(); scl_h = 0; qw();
   endtask
   task automatic bus_stop();
      sda_h = 0; qw(); scl_h = 1; qw(); sda_h = 1; qw();
   endtask
   task automatic send_bit(input logic b);
      sda_h = b; qw(); scl_h = 1; qw(); qw(); scl_h = 0; qw();
   endtask
   task automatic recv_bit(output logic b);
      sda_h = 1; qw(); scl_h = 1; qw(); b = sda_bus; qw(); scl_h = 0; qw();
   endtask
   task automatic write_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b);
      ack = ~b;
   endtask
   task automatic read_byte(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) recv_bit(v[i]);
   endtask

   task automatic txn_write(input logic [2:0] a, input logic [7:0] c, input logic [7:0] d,
                            output logic [2:0] acks, output logic rel);
      bus_start();
      write_byte({4'hA, a, 1'b0}, acks[0]);
      write_byte(c, acks[1]);
      write_byte(d, acks[2]);
      rel = ~sda_oe;
      bus_stop();
   endtask

   task automatic txn_read(input logic [2:0] a, input logic [7:0] c,
                           output logic [2:0] acks, output logic [7:0] v, output logic rel);
      bus_start();
      write_byte({4'hA, a, 1'b0}, acks[0]);
      write_byte(c, acks[1]);
      bus_rstart();
      write_byte({4'hA, a, 1'b1}, acks[2]);
      read_byte(v);
      rel = ~sda_oe;
      send_bit(1'b1);
      bus_stop();
   endtask

   task automatic wait_idle();
      for (int t = 0; t < SETTLE + 100 && busy; t++) @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (300000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] acks;
      logic [7:0] v;
      logic rel, ack;
      for (int i = 0; i < 128; i++) model[i] = rom_byte(i);
      for (int i = 128; i < 256; i++) model[i] = 8'h00;
      repeat (5) @(posedge clk);
      #1;
      chk(sda_oe == 0, "R10 sda released in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      chk(sda_oe == 0, "R10 sda released after reset", sda_oe, 0);
      chk(busy == 0, "R10 busy low after reset", busy, 0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         logic [7:0] c, d;
         c = VEC[k][15:8];
         d = VEC[k][7:0];
         if (VEC[k][16]) begin
            txn_read(STRAP, c, acks, v, rel);
            chk(acks == 3'b111, "R5 read acks", acks, 7);
            chk(v == model[c], c[7] ? "R5/R10 scratch read" : "R6 table read", v, model[c]);
            chk(rel, "R8 release after read data", !rel, 0);
         end else begin
            txn_write(STRAP, c, d, acks, rel);
            chk(acks == 3'b111, c[7] ? "R3 write acks" : "R4 table write acks", acks, 7);
            chk(rel, "R8 release after ack clock", !rel, 0);
            if (c[7]) model[c] = d;
            wait_idle();
         end
      end

      // R7: settling interval length and refusal
      busy_cnt = 0;
      txn_write(STRAP, 8'h90, 8'h77, acks, rel);
      model[8'h90] = 8'h77;
      chk(busy == 1, "R7 busy after scratch write", busy, 1);
      bus_start();
      write_byte({4'hA, STRAP, 1'b0}, ack);
      chk(ack == 0, "R7 address refused while busy", ack, 0);
      bus_stop();
      wait_idle();
      repeat (3) @(posedge clk);
      #1;
      chk(busy_cnt == SETTLE, "R7 busy length", busy_cnt, SETTLE);
      txn_read(STRAP, 8'h90, acks, v, rel);
      chk(v == 8'h77, "R3 read back after settle", v, 8'h77);

      // R4: table write does not start settling and changes nothing
      txn_write(STRAP, 8'h10, 8'hEE, acks, rel);
      chk(acks == 3'b111, "R4 acks", acks, 7);
      repeat (4) @(posedge clk);
      #1;
      chk(busy == 0, "R4 no busy", busy, 0);
      txn_read(STRAP, 8'h10, acks, v, rel);
      chk(v == rom_byte(16), "R4 table unchanged", v, rom_byte(16));

      // R2: wrong strap address
      txn_write(3'b010, 8'h80, 8'h00, acks, rel);
      chk(acks == 3'b000, "R2 no acks for other address", acks, 0);
      chk(busy == 0, "R2 no busy", busy, 0);
      txn_read(STRAP, 8'h80, acks, v, rel);
      chk(v == model[8'h80], "R2 scratch unchanged", v, model[8'h80]);

      // R1: strap change moves the address
      strap = 3'b010;
      repeat (4) @(posedge clk);
      #1;
      txn_write(3'b010, 8'h85, 8'h42, acks, rel);
      chk(acks == 3'b111, "R1 new strap address acked", acks, 7);
      model[8'h85] = 8'h42;
      wait_idle();
      bus_start();
      write_byte({4'hA, STRAP, 1'b0}, ack);
      chk(ack == 0, "R1 old strap address refused", ack, 0);
      bus_stop();
      txn_read(3'b010, 8'h85, acks, v, rel);
      chk(v == 8'h42, "R1 read at new strap", v, 8'h42);
      strap = STRAP;
      repeat (4) @(posedge clk);
      #1;

      // R9: STOP in mid byte
      bus_start();
      write_byte({4'hA, STRAP, 1'b0}, ack);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      bus_stop();
      chk(sda_oe == 0, "R9 released after stop", sda_oe, 0);
      txn_read(STRAP, 8'h7F, acks, v, rel);
      chk(acks == 3'b111 && v == rom_byte(127), "R9 clean after stop", v, rom_byte(127));

      // R9: START in mid byte keeps latched command 0x7F
      bus_start();
      write_byte({4'hA, STRAP, 1'b0}, ack);
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
      bus_rstart();
      write_byte({4'hA, STRAP, 1'b1}, ack);
      read_byte(v);
      send_bit(1'b1);
      bus_stop();
      chk(ack == 1, "R9 address after mid-byte start", ack, 1);
      chk(v == rom_byte(127), "R9 latched command kept", v, rom_byte(127));

      chk(r8_viol == 0, "R8 drive changed with SCL high", r8_viol, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule